// File: doc/BRIEF.md
# Autobaud Boot Command Responder

This block is the serial front end of a boot loader. The host opens every packet with a `>` character. The block treats that character only as a timing reference and measures the host's bit time from its waveform. It then receives the rest of the packet as 8N1 characters at the measured rate. Each character is sampled at the middle of its bits.

A valid packet is a space, the word `Prop_Chk`, and four hexadecimal arguments. A single space goes in front of each argument. The fourth argument must be closed by a non-hex character. When a packet is complete, the block waits for a turnaround gap. It then sends a 15-character reply at the measured bit time: CR, LF, `Prop_Ver `, a two-character version tag taken from `ver_code`, CR, LF. The link is half duplex. Input is ignored while the reply is pending or being sent. After every reply, parse mismatch, framing error or long silence, the block measures the timing character again.

Three state machines do the work. The receiver moves through the states HUNT, LEAD, RUN, TAIL, IDLE, START, DATA and STOP:
- HUNT goes to LEAD on a falling edge.
- LEAD goes to RUN if the low run is at least two minimum bits.
- RUN goes to TAIL if the high run is 4 to 6 bit times.
- TAIL goes to IDLE if the low run is 1 to 3 bit times.
- IDLE goes to START on a falling edge.
- START goes to DATA at half a bit, or back to IDLE on a glitch.
- DATA goes to STOP after 8 bits.
- STOP goes to IDLE with a character, or to HUNT on a framing error.
- Any failed check, an idle timeout, a hold or a restart sends the receiver to HUNT.

The parser moves through WORD, FIRST and MORE:
- WORD steps through ` Prop_Chk ` and moves to FIRST after the last character.
- FIRST moves to MORE on a hex digit.
- MORE stays in MORE on hex digits and goes back to FIRST on a space that ends argument 1 to 3.
- A non-hex character that ends argument 4 fires the reply.
- Any other character is a mismatch and returns the parser to WORD.

The transmitter moves through IDLE, TURN, START, DATA and STOP:
- IDLE goes to TURN when the reply fires.
- TURN goes to START when the gap has elapsed.
- START, DATA and STOP send one character; STOP loops back to START for the next character, or to IDLE after 15 characters.

Top module: `boot_chk_responder`

## Requirements
- R1: During and after reset, with no reply in progress, `ser_tx` stays high (idle).
- R2: The bit time is measured from the `>` character: half the length of its leading low run (start bit plus data bit 0). It is accepted only if that low run is at least `2*MIN_BIT` cycles, the following high run is 4 to 6 bit times, and the last low run is 1 to 3 bit times. The measured value stays constant while characters are being received.
- R3: After `>`, the next characters must be exactly a space and then case-sensitive `Prop_Chk`. Any deviation produces no reply.
- R4: A single space goes in front of each of the four arguments. Each argument is one or more of the digits 0-9, A-F and a-f. A doubled space, a missing digit, or another character ending argument 1 to 3 produces no reply.
- R5: No reply starts until the fourth argument has been closed by a non-hex character, such as a space or CR (0x0D).
- R6: The reply is 15 characters: 0x0D, 0x0A, `Prop_Ver `, then `ver_code[15:8]` and `ver_code[7:0]`, then 0x0D, 0x0A. It is sent LSB first in 8N1 format, and every bit lasts exactly the measured bit time.
- R7: The start bit of the reply begins `TURN_CYCLES` to `TURN_CYCLES + bit time + 10` clock cycles after the stop bit of the terminating character begins. `ser_tx` stays high during the gap.
- R8: After a mismatch, a framing error, or more than 2^`GAP_SHIFT` bit times of silence within a packet, the block goes back to measuring a new `>`. A later valid packet is then answered.
- R9: Characters that arrive while the reply is pending or being sent are ignored. The reply is not changed, and they cause no extra reply.
- R10: Back-to-back packets, possibly at different bit rates and with different version tags, each produce exactly one reply when the gap between packets covers the reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_rx | input | 1 | Serial receive line from the host (idle high) |
| ver_code | input | 16 | Two ASCII characters of the version tag (upper byte sent first) |
| ser_tx | output | 1 | Serial transmit line to the host (idle high) |

## Verification
The checker watches the internal boundaries on every clock cycle:
- the transmit line stays high while idle and during the turnaround gap;
- a completed packet always starts the turnaround;
- the receiver never delivers a character or stays locked while the reply is active;
- the measured bit time stays frozen while the receiver is locked;
- a packet never completes and fails in the same cycle.

Only the bench scenarios can show the rest:
- that the reply bytes are correct at several measured rates;
- that the reply arrives inside the turnaround window;
- that malformed packets and unterminated arguments produce silence;
- that traffic during a reply leaves it unchanged.

// File: rtl/boot_chk_pkg.sv
package boot_chk_pkg;

    typedef enum logic [2:0] {
        RX_HUNT, RX_LEAD, RX_RUN, RX_TAIL, RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        PS_WORD, PS_FIRST, PS_MORE
    } ps_state_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_TURN, TX_START, TX_DATA, TX_STOP
    } tx_state_e;

    localparam int KEY_LEN   = 10;
    localparam int REPLY_LEN = 15;

    // Expected text after the timing character: space, keyword, space
    function automatic logic [7:0] key_char(input logic [3:0] idx);
        case (idx)
            4'd0:    key_char = 8'h20;
            4'd1:    key_char = "P";
            4'd2:    key_char = "r";
            4'd3:    key_char = "o";
            4'd4:    key_char = "p";
            4'd5:    key_char = "_";
            4'd6:    key_char = "C";
            4'd7:    key_char = "h";
            4'd8:    key_char = "k";
            default: key_char = 8'h20;
        endcase
    endfunction

    function automatic logic is_hex(input logic [7:0] c);
        is_hex = (c >= "0" && c <= "9") || (c >= "A" && c <= "F") ||
                 (c >= "a" && c <= "f");
    endfunction

    function automatic logic [7:0] reply_char(input logic [3:0] idx,
                                              input logic [15:0] ver);
        case (idx)
            4'd0:    reply_char = 8'h0D;
            4'd1:    reply_char = 8'h0A;
            4'd2:    reply_char = "P";
            4'd3:    reply_char = "r";
            4'd4:    reply_char = "o";
            4'd5:    reply_char = "p";
            4'd6:    reply_char = "_";
            4'd7:    reply_char = "V";
            4'd8:    reply_char = "e";
            4'd9:    reply_char = "r";
            4'd10:   reply_char = 8'h20;
            4'd11:   reply_char = ver[15:8];
            4'd12:   reply_char = ver[7:0];
            4'd13:   reply_char = 8'h0D;
            default: reply_char = 8'h0A;
        endcase
    endfunction

endpackage

// File: rtl/boot_autobaud_rx.sv
module boot_autobaud_rx
    import boot_chk_pkg::*;
#(
    parameter int BW        = 16,
    parameter int GAP_SHIFT = 7,
    parameter int MIN_BIT   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    input  logic          hold,
    input  logic          restart,
    output logic [BW-1:0] bit_len,
    output logic          synced,
    output logic          c_valid,
    output logic [7:0]    c_data
);
    localparam int CW = BW + GAP_SHIFT + 1;
    localparam logic [CW-1:0] LEAD_MAX = CW'((64'd1 << (BW + 1)) - 1);
    localparam logic [CW-1:0] LEAD_MIN = CW'(2 * MIN_BIT);

    rx_state_e      st_q;
    logic [CW-1:0]  cnt_q;
    logic [BW-1:0]  bl_q;
    logic [7:0]     sh_q, data_q;
    logic [2:0]     bi_q;
    logic           s1_q, s2_q, valid_q;

    logic [CW-1:0]  bl_w, half_w, three_w, four_w, six_w, gap_w;
    assign bl_w    = CW'(bl_q);
    assign half_w  = bl_w >> 1;
    assign three_w = bl_w + (bl_w << 1);
    assign four_w  = bl_w << 2;
    assign six_w   = four_w + (bl_w << 1);
    assign gap_w   = bl_w << GAP_SHIFT;

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_HUNT;
            cnt_q   <= '0;
            bl_q    <= '0;
            sh_q    <= '0;
            data_q  <= '0;
            bi_q    <= '0;
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            valid_q <= 1'b0;
        end else begin
            s1_q    <= line_in;
            s2_q    <= s1_q;
            valid_q <= 1'b0;
            if (hold || restart) begin
                st_q  <= RX_HUNT;
                cnt_q <= '0;
            end else begin
                unique case (st_q)
                    RX_HUNT: if (!s2_q) begin
                        st_q <= RX_LEAD; cnt_q <= CW'(1);
                    end
                    RX_LEAD: if (s2_q) begin
                        if (cnt_q >= LEAD_MIN) begin
                            bl_q <= cnt_q[BW:1]; st_q <= RX_RUN; cnt_q <= CW'(1);
                        end else st_q <= RX_HUNT;
                    end else if (cnt_q == LEAD_MAX) st_q <= RX_HUNT;
                    else cnt_q <= cnt_q + 1'b1;
                    RX_RUN: if (!s2_q) begin
                        if (cnt_q >= four_w) begin
                            st_q <= RX_TAIL; cnt_q <= CW'(1);
                        end else st_q <= RX_HUNT;
                    end else if (cnt_q > six_w) st_q <= RX_HUNT;
                    else cnt_q <= cnt_q + 1'b1;
                    RX_TAIL: if (s2_q) begin
                        if (cnt_q >= bl_w && cnt_q <= three_w) begin
                            st_q <= RX_IDLE; cnt_q <= CW'(1);
                        end else st_q <= RX_HUNT;
                    end else if (cnt_q > three_w) st_q <= RX_HUNT;
                    else cnt_q <= cnt_q + 1'b1;
                    RX_IDLE: if (!s2_q) begin
                        st_q <= RX_START; cnt_q <= CW'(1);
                    end else if (cnt_q >= gap_w) st_q <= RX_HUNT;
                    else cnt_q <= cnt_q + 1'b1;
                    RX_START: if (cnt_q >= half_w) begin
                        cnt_q <= CW'(1);
                        bi_q  <= '0;
                        st_q  <= s2_q ? RX_IDLE : RX_DATA;
                    end else cnt_q <= cnt_q + 1'b1;
                    RX_DATA: if (cnt_q >= bl_w) begin
                        sh_q  <= {s2_q, sh_q[7:1]};
                        cnt_q <= CW'(1);
                        if (bi_q == 3'd7) st_q <= RX_STOP;
                        else bi_q <= bi_q + 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                    RX_STOP: if (cnt_q >= bl_w) begin
                        cnt_q <= CW'(1);
                        if (s2_q) begin
                            valid_q <= 1'b1; data_q <= sh_q; st_q <= RX_IDLE;
                        end else st_q <= RX_HUNT;
                    end else cnt_q <= cnt_q + 1'b1;
                    default: st_q <= RX_HUNT;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        bit_len = bl_q;
        c_valid = valid_q;
        c_data  = data_q;
        synced  = (st_q == RX_IDLE) || (st_q == RX_START) ||
                  (st_q == RX_DATA) || (st_q == RX_STOP);
    end

endmodule

// File: rtl/boot_cmd_parser.sv
module boot_cmd_parser
    import boot_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       synced,
    input  logic       c_valid,
    input  logic [7:0] c_data,
    output logic       fire,
    output logic       bad
);
    ps_state_e  ps_q;
    logic [3:0] kidx_q;
    logic [1:0] arg_q;
    logic       hex;

    assign hex = is_hex(c_data);

    // Outputs: completion and mismatch
    always_comb begin
        fire = 1'b0;
        bad  = 1'b0;
        if (synced && c_valid) begin
            unique case (ps_q)
                PS_WORD:  bad = (c_data != key_char(kidx_q));
                PS_FIRST: bad = !hex;
                PS_MORE: begin
                    fire = !hex && (arg_q == 2'd3);
                    bad  = !hex && (arg_q != 2'd3) && (c_data != 8'h20);
                end
                default:  bad = 1'b1;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || !synced) begin
            ps_q   <= PS_WORD;
            kidx_q <= '0;
            arg_q  <= '0;
        end else if (c_valid) begin
            if (fire || bad) begin
                ps_q   <= PS_WORD;
                kidx_q <= '0;
                arg_q  <= '0;
            end else begin
                unique case (ps_q)
                    PS_WORD: begin
                        if (kidx_q == 4'(KEY_LEN - 1)) ps_q <= PS_FIRST;
                        else kidx_q <= kidx_q + 1'b1;
                    end
                    PS_FIRST: ps_q <= PS_MORE;
                    PS_MORE: if (!hex) begin
                        ps_q  <= PS_FIRST;
                        arg_q <= arg_q + 1'b1;
                    end
                    default: ps_q <= PS_WORD;
                endcase
            end
        end
    end

endmodule

// File: rtl/boot_reply_tx.sv
module boot_reply_tx
    import boot_chk_pkg::*;
#(
    parameter int BW          = 16,
    parameter int TURN_CYCLES = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [BW-1:0] bit_len,
    input  logic [15:0]   ver,
    output logic          tx,
    output logic          busy,
    output logic          turning
);
    localparam int TW = $clog2(TURN_CYCLES + 1);
    localparam int CW = ((TW > BW) ? TW : BW) + 1;

    tx_state_e     st_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    ci_q;
    logic [2:0]    bi_q;
    logic [7:0]    sh_q;
    logic [CW-1:0] bl_w;

    assign bl_w = CW'(bit_len);

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            cnt_q <= '0;
            ci_q  <= '0;
            bi_q  <= '0;
            sh_q  <= '0;
        end else begin
            unique case (st_q)
                TX_IDLE: if (start) begin
                    st_q <= TX_TURN; cnt_q <= CW'(1);
                end
                TX_TURN: if (cnt_q >= CW'(TURN_CYCLES)) begin
                    st_q <= TX_START; cnt_q <= CW'(1); ci_q <= '0;
                end else cnt_q <= cnt_q + 1'b1;
                TX_START: if (cnt_q >= bl_w) begin
                    st_q  <= TX_DATA;
                    cnt_q <= CW'(1);
                    bi_q  <= '0;
                    sh_q  <= reply_char(ci_q, ver);
                end else cnt_q <= cnt_q + 1'b1;
                TX_DATA: if (cnt_q >= bl_w) begin
                    cnt_q <= CW'(1);
                    sh_q  <= sh_q >> 1;
                    if (bi_q == 3'd7) st_q <= TX_STOP;
                    else bi_q <= bi_q + 1'b1;
                end else cnt_q <= cnt_q + 1'b1;
                TX_STOP: if (cnt_q >= bl_w) begin
                    cnt_q <= CW'(1);
                    if (ci_q == 4'(REPLY_LEN - 1)) st_q <= TX_IDLE;
                    else begin
                        ci_q <= ci_q + 1'b1;
                        st_q <= TX_START;
                    end
                end else cnt_q <= cnt_q + 1'b1;
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = (st_q != TX_IDLE);
        turning = (st_q == TX_TURN);
        unique case (st_q)
            TX_START: tx = 1'b0;
            TX_DATA:  tx = sh_q[0];
            default:  tx = 1'b1;
        endcase
    end

endmodule

// File: rtl/boot_chk_responder.sv
module boot_chk_responder #(
    parameter int BW          = 16,
    parameter int TURN_CYCLES = 50000,
    parameter int GAP_SHIFT   = 7,
    parameter int MIN_BIT     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_rx,
    input  logic [15:0] ver_code,
    output logic        ser_tx
);
    logic [BW-1:0] rx_bit_len;
    logic          rx_synced, rx_valid, p_fire, p_bad;
    logic [7:0]    rx_data;
    logic          tx_busy, tx_turning, rx_hold;

    assign rx_hold = tx_busy | p_fire;

    boot_autobaud_rx #(.BW(BW), .GAP_SHIFT(GAP_SHIFT), .MIN_BIT(MIN_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .line_in(ser_rx), .hold(rx_hold),
        .restart(p_bad), .bit_len(rx_bit_len), .synced(rx_synced),
        .c_valid(rx_valid), .c_data(rx_data)
    );

    boot_cmd_parser u_parse (
        .clk(clk), .rst_n(rst_n), .synced(rx_synced), .c_valid(rx_valid),
        .c_data(rx_data), .fire(p_fire), .bad(p_bad)
    );

    boot_reply_tx #(.BW(BW), .TURN_CYCLES(TURN_CYCLES)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(p_fire), .bit_len(rx_bit_len),
        .ver(ver_code), .tx(ser_tx), .busy(tx_busy), .turning(tx_turning)
    );

endmodule

// File: rtl/boot_chk_responder_sva.sv
module boot_chk_responder_sva #(
    parameter int BW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_tx,
    input logic          tx_busy,
    input logic          tx_turning,
    input logic          fire,
    input logic          bad,
    input logic          c_valid,
    input logic          synced,
    input logic [BW-1:0] bit_len
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> ser_tx); // R1

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (synced && $past(synced)) |-> $stable(bit_len)); // R2

    AST_FIRE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (tx_busy && tx_turning)); // R5

    AST_TURN_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_turning) |-> $past(fire)); // R5

    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_turning |-> ser_tx); // R7

    AST_FIRE_XOR_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && bad)); // R8

    AST_DEAF_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> (!c_valid && !synced)); // R9

endmodule

bind boot_chk_responder boot_chk_responder_sva #(.BW(BW)) u_sva (
    .clk(clk), .rst_n(rst_n), .ser_tx(ser_tx), .tx_busy(tx_busy),
    .tx_turning(tx_turning), .fire(p_fire), .bad(p_bad), .c_valid(rx_valid),
    .synced(rx_synced), .bit_len(rx_bit_len)
);

// File: tb/sim_boot_chk_responder.sv
module sim_boot_chk_responder;
    localparam int TURN = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_rx = 1'b1;
    logic [15:0] ver = {8'h46, 8'h31};
    logic        ser_tx;

    int checks = 0, errors = 0, cyc = 0;
    int cur_b = 16;
    byte mon_buf [0:63];
    int  mon_n = 0, first_start = 0, t_stop = 0;
    byte pkt [0:63];
    int  plen = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    boot_chk_responder #(.TURN_CYCLES(TURN)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_rx(ser_rx), .ver_code(ver), .ser_tx(ser_tx)
    );

    // Reply decoder on the transmit line
    initial begin
        forever begin
            @(negedge clk);
            if (ser_tx === 1'b0) begin
                logic [7:0] d;
                if (mon_n == 0) first_start = cyc;
                repeat (cur_b / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (cur_b) @(negedge clk);
                    d[i] = ser_tx;
                end
                repeat (cur_b) @(negedge clk);
                if (mon_n < 64) mon_buf[mon_n] = d;
                mon_n = mon_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic byte exp_reply(input int i);
        string head = "\r\nProp_Ver ";
        if (i < 11) return head[i];
        if (i == 11) return ver[15:8];
        if (i == 12) return ver[7:0];
        if (i == 13) return 8'h0D;
        return 8'h0A;
    endfunction

    task automatic send_char(input byte c);
        ser_rx = 1'b0;
        repeat (cur_b) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rx = c[i];
            repeat (cur_b) @(negedge clk);
        end
        ser_rx = 1'b1;
        t_stop = cyc;
        repeat (cur_b) @(negedge clk);
    endtask

    task automatic push(input byte c);
        pkt[plen] = c;
        plen++;
    endtask

    task automatic push_str(input string s);
        for (int i = 0; i < s.len(); i++) push(s[i]);
    endtask

    task automatic send_pkt();
        for (int i = 0; i < plen; i++) send_char(pkt[i]);
        plen = 0;
    endtask

    task automatic send_str(input string s);
        push_str(s);
        send_pkt();
    endtask

    task automatic wait_reply();
        repeat (TURN + 16 * 10 * cur_b + 50) @(negedge clk);
    endtask

    task automatic settle();
        repeat (200 * cur_b) @(negedge clk);
    endtask

    task automatic check_reply(input string req);
        int bad_n = 0;
        chk(mon_n == 15, req, "reply length", mon_n, 15);
        for (int i = 0; i < 15; i++)
            if (mon_buf[i] != exp_reply(i)) bad_n++;
        chk(bad_n == 0, req, "reply bytes wrong", bad_n, 0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=%0d expected=finish", cyc);
        finish_run();
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        // R1: line idle through and after reset
        repeat (5) @(negedge clk);
        chk(ser_tx === 1'b1, "R1", "tx in reset", ser_tx, 1);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(ser_tx === 1'b1, "R1", "tx after reset", ser_tx, 1);

        // R2 R6 R7: basic packet
        cur_b = 16; mon_n = 0;
        send_str("> Prop_Chk 0 0 0 0 ");
        wait_reply();
        check_reply("R6");
        chk(first_start - t_stop >= TURN && first_start - t_stop <= TURN + cur_b + 10,
            "R7", "turnaround", first_start - t_stop, TURN);

        // R5: unterminated fourth argument, then CR
        mon_n = 0;
        send_str("> Prop_Chk 1A 2b 3C 4d");
        repeat (TURN + 400) @(negedge clk);
        chk(mon_n == 0, "R5", "reply before terminator", mon_n, 0);
        send_char(8'h0D);
        wait_reply();
        check_reply("R5");

        // R3 R4: malformed packets
        mon_n = 0;
        send_str("> prop_Chk 0 0 0 0 "); settle();
        chk(mon_n == 0, "R3", "lower-case keyword", mon_n, 0);
        send_str(">Prop_Chk 0 0 0 0 "); settle();
        chk(mon_n == 0, "R3", "missing space", mon_n, 0);
        send_str("> Prop_Chk 0 0 G 0 "); settle();
        chk(mon_n == 0, "R4", "non-hex argument", mon_n, 0);
        send_str("> Prop_Chk 0  0 0 0 "); settle();
        chk(mon_n == 0, "R4", "double space", mon_n, 0);
        // R8: recovery
        send_str("> Prop_Chk f 0 9 0 ");
        wait_reply();
        check_reply("R8");

        // R9: traffic during reply is ignored
        mon_n = 0;
        send_str("> Prop_Chk 7 7 7 7 ");
        repeat (TURN + 30 * cur_b) @(negedge clk);
        send_str("> Pr");
        wait_reply();
        settle();
        check_reply("R9");

        // R10: back-to-back random packets at varied rates
        for (int k = 0; k < 4; k++) begin
            cur_b = 8 + int'($urandom % 17);
            ver = {8'(8'h41 + $urandom % 26), 8'(8'h30 + $urandom % 10)};
            mon_n = 0;
            push_str("> Prop_Chk");
            for (int a = 0; a < 4; a++) begin
                int nd;
                push(8'h20);
                nd = 1 + int'($urandom % 3);
                for (int j = 0; j < nd; j++) begin
                    int d;
                    d = int'($urandom % 16);
                    if (d < 10) push(8'(8'h30 + d));
                    else if ($urandom % 2 == 0) push(8'(8'h41 + d - 10));
                    else push(8'(8'h61 + d - 10));
                end
            end
            push((k % 2 == 1) ? 8'h20 : 8'h0D);
            send_pkt();
            wait_reply();
            check_reply("R10");
        end
        cur_b = 16;
        finish_run();
    end

endmodule